// File: doc/BRIEF.md
# Token-Steered Column Gray-Level Loader

This block fills a row of column registers for a bistable display column driver, one 6-bit gray level per column (64 levels). Data words are not shifted through the row. A single one-hot token walks along the columns, one position per shift clock. Only the column that holds the token copies the data bus into its staging register. When the whole line is staged, a latch strobe copies every staging register at once into the held register that feeds the waveform generators. The held line stays stable while the next line is staged.

The row has 200 columns. A narrow mode limits the active row to the first 192 columns. The travel direction can be selected. By default the token starts at column 0 and moves toward higher columns. In reverse it starts at the last active column and moves toward column 0. A cascade output announces that the token sits in the last active stage. If that output is wired to the next driver's token input, the next driver picks up the line without a gap.

Top module: `col_token_loader`

## Requirements
- R1: An active-low reset clears the token, the cascade output, all staging registers and all held registers to zero.
- R2: When `tok_in` is 1 at a clock edge, the token is placed on the entry column and any token already in flight is discarded. The entry column is column 0 when `dir`=0, and the last active column when `dir`=1.
- R3: At each edge, the column holding the token before that edge captures `data_in`. The token then moves one column: toward higher indices when `dir`=0, toward lower indices when `dir`=1.
- R4: With `narrow`=1 the active row is columns 0 to 191. Columns 192 to 199 never hold the token and keep their staging contents.
- R5: `tok_out` is 1 for exactly the one clock period in which the token occupies the last active stage. That stage is column 191 or 199 when `dir`=0, and column 0 when `dir`=1.
- R6: After the token leaves the last active stage, no column captures data until a new token arrives on `tok_in`.
- R7: When `lat` is 1 at an edge, every held register takes the value its staging register had before that edge.
- R8: Held registers do not change at any edge where `lat` is 0, including while a line is being staged.
- R9: `col_data` carries the held value of column c in bits [c*6+5 : c*6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_in | input | 1 | Token injection, starts a line |
| dir | input | 1 | Travel direction: 0 upward from column 0, 1 downward from the last active column |
| narrow | input | 1 | 1 limits the row to 192 active columns |
| data_in | input | 6 | Gray level for the column holding the token |
| lat | input | 1 | Copy staging registers into held registers |
| tok_out | output | 1 | Cascade token, high while the last active stage holds the token |
| col_data | output | NUM_COLS*6 | Held gray levels, column c at bits [c*6 +: 6] |

## Verification
The bench runs a small row in all four direction and width combinations and tracks where the token sits at every edge. Staging the full-width line first exposes a narrow-mode design that lets the token spill into the idle columns: those columns would be overwritten. Idle cycles with all-ones data after each line catch a token that wraps around or lingers, which would corrupt the first columns. A mid-line reinjection and a strobe that arrives on the same edge as a capture catch designs that either keep two tokens or latch the post-edge staging value. The cascade output is checked every cycle, so a pulse that arrives one cycle late or lasts two cycles is reported.

// File: rtl/col_loader_pkg.sv
`timescale 1ns/1ps
package col_loader_pkg;
    localparam int DEF_COLS   = 200;
    localparam int DEF_NARROW = 192;
    localparam int GRAY_W     = 6;
endpackage

// File: rtl/col_token_chain.sv
`timescale 1ns/1ps
module col_token_chain #(
    parameter int NUM_COLS    = 200,
    parameter int NARROW_COLS = 192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tok_in,
    input  logic                dir,
    input  logic                narrow,
    output logic [NUM_COLS-1:0] tok_vec,
    output logic                tok_out
);
    localparam int IDX_W = $clog2(NUM_COLS);
    localparam logic [IDX_W-1:0] LAST_FULL   = IDX_W'(NUM_COLS - 1);
    localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NARROW_COLS - 1);

    typedef struct packed {
        logic [NUM_COLS-1:0] tok;
        logic                tout;
    } chain_t;

    chain_t st_d, st_q;

    logic [IDX_W-1:0]    top_idx;
    logic [IDX_W-1:0]    exit_idx;
    logic [NUM_COLS-1:0] act_mask;
    logic [NUM_COLS-1:0] entry_vec;
    logic [NUM_COLS-1:0] moved;

    always_comb begin
        top_idx  = narrow ? LAST_NARROW : LAST_FULL;
        exit_idx = dir ? '0 : top_idx;
        for (int c = 0; c < NUM_COLS; c++) begin
            act_mask[c]  = (c <= int'(top_idx));
            entry_vec[c] = dir ? (c == int'(top_idx)) : (c == 0);
        end
        moved = dir ? (st_q.tok >> 1) : (st_q.tok << 1);

        st_d      = st_q;
        st_d.tok  = tok_in ? entry_vec : (moved & act_mask);
        st_d.tout = st_d.tok[exit_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tok_vec = st_q.tok;
    assign tok_out = st_q.tout;
endmodule

// File: rtl/col_data_store.sv
`timescale 1ns/1ps
module col_data_store #(
    parameter int NUM_COLS = 200,
    parameter int DATA_W   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_COLS-1:0]          cap_en,
    input  logic [DATA_W-1:0]            data_in,
    input  logic                         lat,
    output logic [NUM_COLS*DATA_W-1:0]   tmp_flat,
    output logic [NUM_COLS*DATA_W-1:0]   held_flat
);
    typedef struct packed {
        logic [DATA_W-1:0] tmp;
        logic [DATA_W-1:0] held;
    } col_t;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        col_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (cap_en[c]) st_d.tmp  = data_in;
            if (lat)       st_d.held = st_q.tmp;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign tmp_flat[c*DATA_W +: DATA_W]  = st_q.tmp;
        assign held_flat[c*DATA_W +: DATA_W] = st_q.held;
    end
endmodule

// File: rtl/col_token_loader.sv
`timescale 1ns/1ps
module col_token_loader
    import col_loader_pkg::*;
#(
    parameter int NUM_COLS    = DEF_COLS,
    parameter int NARROW_COLS = DEF_NARROW,
    parameter int DATA_W      = GRAY_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tok_in,
    input  logic                       dir,
    input  logic                       narrow,
    input  logic [DATA_W-1:0]          data_in,
    input  logic                       lat,
    output logic                       tok_out,
    output logic [NUM_COLS*DATA_W-1:0] col_data
);
    logic [NUM_COLS-1:0]        tok_vec;
    logic [NUM_COLS*DATA_W-1:0] tmp_vec;

    col_token_chain #(
        .NUM_COLS   (NUM_COLS),
        .NARROW_COLS(NARROW_COLS)
    ) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .tok_in (tok_in),
        .dir    (dir),
        .narrow (narrow),
        .tok_vec(tok_vec),
        .tok_out(tok_out)
    );

    col_data_store #(
        .NUM_COLS(NUM_COLS),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (tok_vec),
        .data_in  (data_in),
        .lat      (lat),
        .tmp_flat (tmp_vec),
        .held_flat(col_data)
    );
endmodule

// File: rtl/col_token_loader_chk.sv
`timescale 1ns/1ps
module col_token_loader_chk #(
    parameter int NUM_COLS    = 200,
    parameter int NARROW_COLS = 192,
    parameter int DATA_W      = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tok_in,
    input logic                       dir,
    input logic                       narrow,
    input logic                       lat,
    input logic                       tok_out,
    input logic [NUM_COLS-1:0]        tok_vec,
    input logic [NUM_COLS*DATA_W-1:0] tmp_vec,
    input logic [NUM_COLS*DATA_W-1:0] col_data
);
    assert_single_token_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok_vec));

    assert_entry_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && !dir) |=> tok_vec[0]);

    assert_entry_down_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && dir && narrow) |=> tok_vec[NARROW_COLS-1]);

    assert_entry_down_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && dir && !narrow) |=> tok_vec[NUM_COLS-1]);

    assert_idle_columns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(narrow) |-> (tok_vec[NUM_COLS-1:NARROW_COLS] == '0));

    assert_cascade_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out);

    assert_line_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lat |=> (col_data == $past(tmp_vec)));

    assert_held_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lat |=> $stable(col_data));
endmodule

bind col_token_loader col_token_loader_chk #(
    .NUM_COLS   (NUM_COLS),
    .NARROW_COLS(NARROW_COLS),
    .DATA_W     (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tok_in  (tok_in),
    .dir     (dir),
    .narrow  (narrow),
    .lat     (lat),
    .tok_out (tok_out),
    .tok_vec (tok_vec),
    .tmp_vec (tmp_vec),
    .col_data(col_data)
);

// File: tb/col_token_loader_test.sv
`timescale 1ns/1ps
module col_token_loader_test;
    localparam int N  = 12;
    localparam int NR = 8;
    localparam int W  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tok_in = 1'b0;
    logic           dir = 1'b0;
    logic           narrow = 1'b0;
    logic [W-1:0]   data_in = '0;
    logic           lat = 1'b0;
    logic           tok_out;
    logic [N*W-1:0] col_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int exp_tmp [N];
    int exp_out [N];
    int pos  = -1;
    int mact = N;
    bit mdir = 0;

    always #4 clk = ~clk;

    col_token_loader #(.NUM_COLS(N), .NARROW_COLS(NR), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .dir(dir), .narrow(narrow),
        .data_in(data_in), .lat(lat), .tok_out(tok_out), .col_data(col_data)
    );

    function automatic int colmap(input int p);
        return mdir ? (mact - 1 - p) : p;
    endfunction

    task automatic check_cols(input string tag);
        for (int c = 0; c < N; c++) begin
            checks++;
            if (int'(col_data[c*W +: W]) != exp_out[c]) begin
                errors++;
                $display("FAIL %s column %0d got %0d exp %0d", tag, c,
                         col_data[c*W +: W], exp_out[c]);
            end
        end
    endtask

    task automatic check_tok(input int exp);
        checks++;
        if (int'(tok_out) != exp) begin
            errors++;
            $display("FAIL R5 tok_out got %0d exp %0d (stage %0d)", tok_out, exp, pos);
        end
    endtask

    // one clock: drive inputs, update the requirement model, check after the edge
    task automatic step(input logic tin, input int d, input logic l);
        @(negedge clk);
        tok_in = tin; data_in = W'(d); lat = l;
        if (l) for (int c = 0; c < N; c++) exp_out[c] = exp_tmp[c];  // R7
        if (pos >= 0) exp_tmp[colmap(pos)] = d;                       // R3
        if (tin) pos = 0;                                              // R2
        else if (pos >= 0) begin
            pos++;
            if (pos == mact) pos = -1;                                 // R6
        end
        @(posedge clk); #1;
        check_tok((pos == mact - 1) ? 1 : 0);
        check_cols(l ? "R7" : "R8");
    endtask

    task automatic set_mode(input bit d, input bit nar);
        @(negedge clk);
        dir = d; narrow = nar; mdir = d; mact = nar ? NR : N;
    endtask

    // stage a full line, idle with all-ones data, then latch it
    task automatic run_line(input int seed);
        step(1'b1, 0, 1'b0);
        for (int i = 0; i < mact; i++) step(1'b0, (seed + i * 11) & 63, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 63, 1'b0);   // R6: nothing captured
        step(1'b0, 0, 1'b1);
        step(1'b0, 5, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tok_in = 0; lat = 0; data_in = '0;
        for (int c = 0; c < N; c++) begin exp_tmp[c] = 0; exp_out[c] = 0; end
        pos = -1;
        repeat (2) @(negedge clk);
        checks++;
        if (tok_out !== 1'b0) begin
            errors++; $display("FAIL R1 tok_out got %0d exp 0", tok_out);
        end
        check_cols("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin exp_tmp[c] = 0; exp_out[c] = 0; end
        do_reset();
        step(1'b0, 9, 1'b1);             // R1: staging was cleared too
        check_cols("R1");

        set_mode(0, 0); run_line(3);     // R3 R9 upward, full row
        set_mode(1, 1); run_line(20);    // R4 downward, narrow: columns 8..11 keep
        set_mode(0, 1); run_line(41);    // R4 upward, narrow
        set_mode(1, 0); run_line(7);     // R3 downward, full row

        // R2: reinject mid-line; the in-flight token still captures on that edge
        set_mode(0, 0);
        step(1'b1, 0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, 50 + i, 1'b0);
        step(1'b1, 33, 1'b0);
        for (int i = 0; i < N; i++) step(1'b0, (i * 5 + 1) & 63, 1'b0);
        step(1'b0, 0, 1'b1);

        // R7: latch on the same edge as a capture takes the pre-edge value
        step(1'b1, 0, 1'b0);
        step(1'b0, 17, 1'b0);
        step(1'b0, 18, 1'b1);
        for (int i = 0; i < N; i++) step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b1);

        // R1: reset in the middle of a line clears everything
        step(1'b1, 0, 1'b0);
        step(1'b0, 44, 1'b0);
        do_reset();
        step(1'b0, 0, 1'b1);
        check_cols("R1");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule